// File: doc/BRIEF.md
# Address-Masked GPIO Port Controller

This block is an eight-pin general-purpose I/O port on a simple memory-mapped bus. The bus has a 4 KB window with a 12-bit byte address, 32-bit data, and separate read and write strobes. Data accesses anywhere in the lowest kilobyte treat address bits [9:2] as a per-pin mask. Software can therefore set, clear or sample single pins without a read-modify-write sequence. Each pin has a direction bit. Output pins drive the stored data bit, and input pins appear high on the output lines. A one-cycle change flag reports every output line whose level moved.

Each input pin goes through a two-flop synchroniser into a detector that can be set per pin for level or edge, rising or falling, or both edges. Detected events set raw status bits. Software clears those bits with a write of ones to the clear register. The bits are masked, and the masked bits are ORed into a single interrupt line.

Writes to the commit register are protected by a two-state lock machine. The state `ST_LOCKED` is entered at reset, and on any lock-register write that does not carry the key 0x0ACCE551 (transition KEY_MISS). The state `ST_OPEN` is entered on a lock-register write of exactly that key (transition KEY_MATCH). With no lock write, the state holds. While the machine is locked, the commit register also serves as the write mask for the alternate-function register.

Alongside these sit storage-only pad-control registers and a read-only identification table.

Top module: `gpio_port`

## Requirements
- R1: A read at any offset below 0x400 returns the data register ANDed with address bits [9:2], with zeros above bit 7. For example, offset 0x008 selects pin 1 only.
- R2: A write at any offset below 0x400 updates only the data bits that are both selected by address bits [9:2] and set in the direction register. All other data bits keep their value.
- R3: The direction register at 0x400 is eight bits wide and resets to 0, so every pin starts as an input. A bit value of 1 makes the pin an output.
- R4: `pin_out[i]` equals data bit i when direction bit i is 1, and equals 1 when direction bit i is 0. All outputs are 0xFF after reset.
- R5: `pin_changed[i]` is 1 in exactly the cycle in which `pin_out[i]` differs from its value in the previous cycle. It is 0 out of reset.
- R6: The interrupt configuration registers can be read and written: level-select at 0x404, both-edges at 0x408, polarity at 0x40C and mask at 0x410. Raw status reads at 0x414. Masked status at 0x418 reads as raw AND mask. `irq` is the OR of the masked status bits.
- R7: With level-select 0 and both-edges 0, a pin sets its raw bit on a rising edge if polarity is 1 and on a falling edge if polarity is 0. With both-edges 1, either edge sets the raw bit. The bit is set by the third rising clock edge after the edge at which `pin_in` changed.
- R8: With level-select 1, the raw bit is set in every cycle in which the synchronised pin equals its polarity bit. A clear write has no effect while that level persists, and it takes effect once the level is gone.
- R9: Writing a 1 to a bit of the clear register at 0x41C clears that raw status bit. A pin whose direction bit is 1 never sets its raw bit.
- R10: The lock register at 0x520 reads 1 while locked and 0 while open. It resets to locked, a write of 0x0ACCE551 opens it, and a write of any other value locks it.
- R11: The commit register at 0x524 resets to 0xFF and takes writes only while the port is open. When the alternate-function register at 0x420 is written while locked, only the bits set in the commit register change. While the port is open, all eight bits change.
- R12: The eight pad-control registers at 0x500 through 0x51C, one per word, store the low eight bits written and reset to 0.
- R13: A read from 0xFD0 to 0xFFC returns entry (offset−0xFD0)/4 of the table 00,00,00,00,61,00,18,01,0D,F0,05,B1.
- R14: Unmapped offsets read 0. Writes to 0x414 and 0x418 have no effect, and write-data bits above bit 7 are ignored. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address within the 4 KB window; bits [1:0] are ignored |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is strobed |
| pin_in | input | 8 | Asynchronous input pin levels |
| pin_out | output | 8 | Output pin levels |
| pin_changed | output | 8 | Per-pin flag that the output level changed this cycle |
| irq | output | 1 | Combined masked interrupt |

## Verification
The following properties are checked on every cycle: the output-line composition, the per-cycle change flags, the masked update of data writes, both lock transitions, the holding of the commit register during locked writes, idle read data, and one identification entry. Several behaviours are visible only through the bench's sequences:
- the three-edge detection latency for each edge and level mode;
- level status persisting through a clear;
- the commit-masked alternate-function update across an unlock and relock;
- the exclusion of output pins from interrupt status.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_DIR    = 12'h400;
    localparam logic [ADDR_W-1:0] OFF_ISENSE = 12'h404;
    localparam logic [ADDR_W-1:0] OFF_IBOTH  = 12'h408;
    localparam logic [ADDR_W-1:0] OFF_IPOL   = 12'h40C;
    localparam logic [ADDR_W-1:0] OFF_IMASK  = 12'h410;
    localparam logic [ADDR_W-1:0] OFF_IRAW   = 12'h414;
    localparam logic [ADDR_W-1:0] OFF_IMSK   = 12'h418;
    localparam logic [ADDR_W-1:0] OFF_ICLR   = 12'h41C;
    localparam logic [ADDR_W-1:0] OFF_ALTFN  = 12'h420;
    localparam logic [ADDR_W-1:0] OFF_PAD0   = 12'h500;
    localparam logic [ADDR_W-1:0] OFF_LOCK   = 12'h520;
    localparam logic [ADDR_W-1:0] OFF_COMMIT = 12'h524;
    localparam logic [ADDR_W-1:0] OFF_IDTAB  = 12'hFD0;

    localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_e;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        logic [7:0] b;
        unique case (idx)
            4'd4:    b = 8'h61;
            4'd6:    b = 8'h18;
            4'd7:    b = 8'h01;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/gpio_lock_fsm.sv
module gpio_lock_fsm
    import gpio_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lock_wr,
    input  logic [31:0] lock_val,
    output logic        locked
);

    lock_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (lock_wr && lock_val == UNLOCK_KEY) state_d = ST_OPEN;   // KEY_MATCH
            ST_OPEN:   if (lock_wr && lock_val != UNLOCK_KEY) state_d = ST_LOCKED; // KEY_MISS
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_OPEN: locked = 1'b0;
            default: locked = 1'b1;
        endcase
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    input  logic [PINS-1:0] dir,
    input  logic [PINS-1:0] level_sel,
    input  logic [PINS-1:0] both_sel,
    input  logic [PINS-1:0] pol_sel,
    input  logic            clr_wr,
    input  logic [PINS-1:0] clr_bits,
    output logic [PINS-1:0] raw_st
);

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        logic s1_q, s2_q, prev_q, hit;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                s1_q   <= pin_in[g];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end

        always_comb begin
            if (level_sel[g])     hit = (s2_q == pol_sel[g]);
            else if (both_sel[g]) hit = s2_q ^ prev_q;
            else if (pol_sel[g])  hit = s2_q & ~prev_q;
            else                  hit = ~s2_q & prev_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) raw_st[g] <= 1'b0;
            else        raw_st[g] <= (raw_st[g] & ~(clr_wr & clr_bits[g])) | (hit & ~dir[g]);
        end
    end

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] data,
    input  logic [PINS-1:0] dir,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_changed
);

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        logic last_q;

        assign pin_out[g] = dir[g] ? data[g] : 1'b1;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) last_q <= 1'b1;
            else        last_q <= pin_out[g];
        end

        assign pin_changed[g] = last_q ^ pin_out[g];
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int PINS = 8,
    parameter int DW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_changed,
    output logic              irq
);

    localparam int DATA_TOP = PINS + 2;
    localparam int NPAD     = 8;
    localparam int PAD_LSB  = $clog2(NPAD) + 2;

    logic [PINS-1:0] dir_q, data_q, isense_q, iboth_q, ipol_q, im_q, altfn_q, cr_q;
    logic [PINS-1:0] pad_q [NPAD];
    logic [PINS-1:0] raw_st, wd, sel, wmask, af_mask, rd_val;
    logic [ADDR_W-1:0] word_addr, id_off;
    logic in_data, in_pad, in_id, locked, lock_wr, clr_wr;
    logic [$clog2(NPAD)-1:0] pad_idx;

    assign word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
    assign in_data   = (bus_addr[ADDR_W-1:DATA_TOP] == '0);
    assign in_pad    = (bus_addr[ADDR_W-1:PAD_LSB] == OFF_PAD0[ADDR_W-1:PAD_LSB]);
    assign in_id     = (bus_addr >= OFF_IDTAB);
    assign pad_idx   = bus_addr[PAD_LSB-1:2];
    assign id_off    = bus_addr - OFF_IDTAB;
    assign sel       = bus_addr[DATA_TOP-1:2];
    assign wd        = bus_wdata[PINS-1:0];
    assign wmask     = sel & dir_q;
    assign af_mask   = locked ? cr_q : '1;
    assign lock_wr   = bus_wr && (word_addr == OFF_LOCK);
    assign clr_wr    = bus_wr && (word_addr == OFF_ICLR);

    gpio_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_wr  (lock_wr),
        .lock_val (bus_wdata),
        .locked   (locked)
    );

    gpio_irq_detect #(.PINS(PINS)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .dir       (dir_q),
        .level_sel (isense_q),
        .both_sel  (iboth_q),
        .pol_sel   (ipol_q),
        .clr_wr    (clr_wr),
        .clr_bits  (wd),
        .raw_st    (raw_st)
    );

    gpio_pin_drive #(.PINS(PINS)) u_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .data        (data_q),
        .dir         (dir_q),
        .pin_out     (pin_out),
        .pin_changed (pin_changed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= '0;
            data_q   <= '0;
            isense_q <= '0;
            iboth_q  <= '0;
            ipol_q   <= '0;
            im_q     <= '0;
            altfn_q  <= '0;
            cr_q     <= '1;
            for (int i = 0; i < NPAD; i++) pad_q[i] <= '0;
        end else if (bus_wr) begin
            if (in_data) begin
                data_q <= (data_q & ~wmask) | (wd & wmask);
            end else if (in_pad) begin
                pad_q[pad_idx] <= wd;
            end else begin
                case (word_addr)
                    OFF_DIR:    dir_q    <= wd;
                    OFF_ISENSE: isense_q <= wd;
                    OFF_IBOTH:  iboth_q  <= wd;
                    OFF_IPOL:   ipol_q   <= wd;
                    OFF_IMASK:  im_q     <= wd;
                    OFF_ALTFN:  altfn_q  <= (altfn_q & ~af_mask) | (wd & af_mask);
                    OFF_COMMIT: if (!locked) cr_q <= wd;
                    default:    ;
                endcase
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (in_data) begin
            rd_val = data_q & sel;
        end else if (in_id) begin
            rd_val = PINS'(id_byte(id_off[5:2]));
        end else if (in_pad) begin
            rd_val = pad_q[pad_idx];
        end else begin
            case (word_addr)
                OFF_DIR:    rd_val = dir_q;
                OFF_ISENSE: rd_val = isense_q;
                OFF_IBOTH:  rd_val = iboth_q;
                OFF_IPOL:   rd_val = ipol_q;
                OFF_IMASK:  rd_val = im_q;
                OFF_IRAW:   rd_val = raw_st;
                OFF_IMSK:   rd_val = raw_st & im_q;
                OFF_ALTFN:  rd_val = altfn_q;
                OFF_LOCK:   rd_val = {{(PINS-1){1'b0}}, locked};
                OFF_COMMIT: rd_val = cr_q;
                default:    rd_val = '0;
            endcase
        end
    end

    assign bus_rdata = bus_rd ? {{(DW-PINS){1'b0}}, rd_val} : '0;
    assign irq       = |(raw_st & im_q);

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int PINS = 8,
    parameter int DW   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_changed,
    input logic              irq,
    input logic [PINS-1:0]   dir_q,
    input logic [PINS-1:0]   data_q,
    input logic [PINS-1:0]   im_q,
    input logic [PINS-1:0]   cr_q,
    input logic              locked
);

    logic [PINS-1:0] m;
    logic            dwr, lwr;
    assign m   = bus_addr[PINS+1:2] & dir_q;
    assign dwr = bus_wr && (bus_addr[ADDR_W-1:PINS+2] == '0);
    assign lwr = bus_wr && ({bus_addr[ADDR_W-1:2], 2'b00} == OFF_LOCK);

    assert_input_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out | dir_q) == '1);

    assert_output_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & dir_q) == (data_q & dir_q));

    assert_change_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (pin_changed == (pin_out ^ $past(pin_out))));

    assert_masked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dwr |=> data_q == (($past(data_q) & ~$past(m)) | ($past(bus_wdata[PINS-1:0]) & $past(m))));

    assert_key_unlock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lwr && bus_wdata == UNLOCK_KEY) |=> !locked);

    assert_key_relock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lwr && bus_wdata != UNLOCK_KEY) |=> locked);

    assert_commit_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && locked) |=> $stable(cr_q));

    assert_irq_needs_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (im_q != '0));

    assert_id_entry_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 12'hFE0) |-> bus_rdata == 32'h61);

    assert_idle_read_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);

endmodule

bind gpio_port gpio_port_chk #(.PINS(PINS), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pin_out     (pin_out),
    .pin_changed (pin_changed),
    .irq         (irq),
    .dir_q       (dir_q),
    .data_q      (data_q),
    .im_q        (im_q),
    .cr_q        (cr_q),
    .locked      (locked)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_changed;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    gpio_port u_gpio_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .pin_changed (pin_changed),
        .irq         (irq)
    );

    typedef struct packed {
        logic        is_wr;
        logic [11:0] addr;
        logic [31:0] val;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h524, 32'h0000_00FF, 8'd11}, // R11 commit reset value
        '{1'b0, 12'h520, 32'h0000_0001, 8'd10}, // R10 locked at reset
        '{1'b0, 12'h400, 32'h0000_0000, 8'd3},  // R3 all inputs
        '{1'b1, 12'h400, 32'h0000_000F, 8'd3},
        '{1'b0, 12'h400, 32'h0000_000F, 8'd3},
        '{1'b1, 12'h3FC, 32'h0000_00AA, 8'd2},  // R2 only outputs updated
        '{1'b0, 12'h3FC, 32'h0000_000A, 8'd1},  // R1 full mask
        '{1'b0, 12'h004, 32'h0000_0000, 8'd1},  // R1 pin 0 only
        '{1'b0, 12'h008, 32'h0000_0002, 8'd1},  // R1 pin 1 only
        '{1'b1, 12'h010, 32'h0000_00FF, 8'd2},  // R2 pin 2 only
        '{1'b0, 12'h3FC, 32'h0000_000E, 8'd2},
        '{1'b1, 12'h500, 32'h0000_1234, 8'd12}, // R12
        '{1'b0, 12'h500, 32'h0000_0034, 8'd12},
        '{1'b1, 12'h51C, 32'h0000_00C3, 8'd12},
        '{1'b0, 12'h51C, 32'h0000_00C3, 8'd12},
        '{1'b0, 12'h504, 32'h0000_0000, 8'd12},
        '{1'b0, 12'hFD0, 32'h0000_0000, 8'd13}, // R13
        '{1'b0, 12'hFE0, 32'h0000_0061, 8'd13},
        '{1'b0, 12'hFE8, 32'h0000_0018, 8'd13},
        '{1'b0, 12'hFF0, 32'h0000_000D, 8'd13},
        '{1'b0, 12'hFFC, 32'h0000_00B1, 8'd13},
        '{1'b0, 12'h600, 32'h0000_0000, 8'd14}, // R14 unmapped
        '{1'b1, 12'h414, 32'h0000_00FF, 8'd14},
        '{1'b0, 12'h414, 32'h0000_0000, 8'd14},
        '{1'b1, 12'h420, 32'h0000_00F0, 8'd11}, // R11 locked, commit FF
        '{1'b0, 12'h420, 32'h0000_00F0, 8'd11},
        '{1'b1, 12'h520, 32'h0ACC_E551, 8'd10}, // R10 key
        '{1'b0, 12'h520, 32'h0000_0000, 8'd10},
        '{1'b1, 12'h524, 32'h0000_000F, 8'd11},
        '{1'b0, 12'h524, 32'h0000_000F, 8'd11},
        '{1'b1, 12'h520, 32'h1234_5678, 8'd10}, // R10 wrong key
        '{1'b0, 12'h520, 32'h0000_0001, 8'd10},
        '{1'b1, 12'h524, 32'h0000_00FF, 8'd11}, // R11 ignored while locked
        '{1'b0, 12'h524, 32'h0000_000F, 8'd11},
        '{1'b1, 12'h420, 32'h0000_000F, 8'd11},
        '{1'b0, 12'h420, 32'h0000_00FF, 8'd11},
        '{1'b1, 12'h420, 32'h0000_0000, 8'd11},
        '{1'b0, 12'h420, 32'h0000_00F0, 8'd11},
        '{1'b1, 12'h410, 32'h0000_0300, 8'd14}, // R14 high bits dropped
        '{1'b0, 12'h410, 32'h0000_0000, 8'd14}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        check($sformatf("%s rd %h", tag, a), bus_rdata, exp);
        bus_rd   = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 reset pin_out", {24'b0, pin_out}, 32'hFF);
        check("R5 reset pin_changed", {24'b0, pin_changed}, 32'h0);
        check("R6 reset irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) bus_write(VECS[i].addr, VECS[i].val);
            else bus_read(VECS[i].addr, VECS[i].val, $sformatf("R%0d", VECS[i].req));
        end

        // R4 pins 0-3 output data 0xE, pins 4-7 inputs
        #1 check("R4 pin_out", {24'b0, pin_out}, 32'hFE);
        // R5 change flags in the cycle of the update only
        bus_write(12'h3FC, 32'h01);
        #1;
        check("R5 changed", {24'b0, pin_changed}, 32'h0F);
        check("R4 pin_out after write", {24'b0, pin_out}, 32'hF1);
        @(negedge clk); #1;
        check("R5 changed clears", {24'b0, pin_changed}, 32'h00);

        // R7 rising edge on pin 4, masked in
        bus_write(12'h40C, 32'h10);
        bus_write(12'h410, 32'h10);
        @(negedge clk); pin_in[4] = 1'b1;
        settle();
        bus_read(12'h414, 32'h10, "R7 rising");
        bus_read(12'h418, 32'h10, "R6 masked");
        check("R6 irq high", {31'b0, irq}, 32'h1);
        bus_write(12'h41C, 32'h10);
        bus_read(12'h414, 32'h00, "R9 clear");
        check("R6 irq low", {31'b0, irq}, 32'h0);

        // R7 falling edge on pin 5, unmasked
        @(negedge clk); pin_in[5] = 1'b1;
        settle();
        bus_read(12'h414, 32'h00, "R7 rise ignored");
        @(negedge clk); pin_in[5] = 1'b0;
        settle();
        bus_read(12'h414, 32'h20, "R7 falling");
        bus_read(12'h418, 32'h00, "R6 mask blocks");
        check("R6 irq masked", {31'b0, irq}, 32'h0);
        bus_write(12'h41C, 32'h20);

        // R7 both edges on pin 6
        bus_write(12'h408, 32'h40);
        @(negedge clk); pin_in[6] = 1'b1;
        settle();
        bus_read(12'h414, 32'h40, "R7 both rise");
        bus_write(12'h41C, 32'h40);
        @(negedge clk); pin_in[6] = 1'b0;
        settle();
        bus_read(12'h414, 32'h40, "R7 both fall");
        bus_write(12'h41C, 32'h40);
        bus_read(12'h414, 32'h00, "R9 clear both");

        // R8 high level on pin 7
        bus_write(12'h40C, 32'h90);
        bus_write(12'h404, 32'h80);
        bus_read(12'h414, 32'h00, "R8 level inactive");
        @(negedge clk); pin_in[7] = 1'b1;
        settle();
        bus_read(12'h414, 32'h80, "R8 level set");
        bus_write(12'h41C, 32'h80);
        bus_read(12'h414, 32'h80, "R8 clear while level");
        @(negedge clk); pin_in[7] = 1'b0;
        settle();
        bus_write(12'h41C, 32'h80);
        bus_read(12'h414, 32'h00, "R8 clear after level");

        // R9 output pin 0 never raises status
        bus_write(12'h40C, 32'h91);
        bus_write(12'h404, 32'h81);
        @(negedge clk); pin_in[0] = 1'b1;
        settle();
        bus_read(12'h414, 32'h00, "R9 output pin");
        check("R9 irq", {31'b0, irq}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule